// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

A performance-monitor block holding a parameterized set of 28-bit event counters behind a 32-bit register port. Slot 0 counts every clock cycle and slot 1 counts cycles on which a stall input is high. Every other slot counts the cycles on which one event strobe is high. That strobe is picked from a 256-wide strobe vector by an 8-bit selector register that belongs to the slot.

Software can load any start value into a counter. Loading the distance to the wrap point turns the counter into a threshold alarm. Each wrap from the all-ones value back to zero sets a sticky status bit. The status bit raises a level interrupt when both the slot's interrupt enable and the global interrupt enable are set. Status bits are cleared through a write-one-to-clear register and can be forced through a write-one-to-set register. A global reset register zeroes every counter and status bit.

Top module: `evmon_bank`

## Requirements
- R1: After reset every counter, control register, selector and status bit reads 0, and the interrupt output is low.
- R2: Offset 0x00 reads the fixed constant 0x00010002. Writes to it have no effect.
- R3: A slot advances by one on a clock edge only when global count enable (0x08 bit 0) and its own count enable (0x100+4*i bit 0) are both set, and its source is high. Slot 0's source is always high. Slot 1's source is the stall input.
- R4: For slot i ≥ 2, the source is the event strobe indexed by the 8-bit selector at 0x140+4*i. Selectors of slots 0 and 1 always read 0 and ignore writes.
- R5: A slot that advances from 0x0FFFFFFF wraps to 0 and sets status bit i (0x30). The bit stays set until it is cleared.
- R6: A write to 0x40+4*i loads bits 27:0 of the write data. The write wins over an increment in the same cycle, and counting resumes from the loaded value. The counter reads back with bits 31:28 as 0.
- R7: Writing 1 to bit i of 0x34 clears status bit i, and 0 bits leave the status unchanged. A wrap in the same cycle keeps the bit set.
- R8: Writing 1 to bit i of 0x3C sets status bit i.
- R9: The interrupt output is high exactly when global interrupt enable (0x08 bit 1) is set and at least one status bit has its slot's interrupt enable (0x100+4*i bit 1) set. It is computed from registered state with no added delay. A slot with count enable set and interrupt enable clear still sets its status bit but never raises the interrupt.
- R10: Any write to 0x0C zeroes all counters and status bits and keeps control and selector registers.
- R11: Control registers keep only bits 1:0. The status register at 0x30 ignores writes. Reads of 0x0C, 0x34, 0x3C and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte offset of the register being accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| evt_i | input | 256 | Event strobe vector |
| stall_i | input | 1 | Wasted-cycle source for slot 1 |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong counter value shows up on the read port in the same cycle that the counter's register is addressed. For that reason the bench sweeps the counter offsets on every idle cycle and compares each read against a behavioural model. A lost or spurious status bit shows on irq_o on the very next clock when its enables are set. Otherwise it shows only on a read of 0x30, so the bench reads the status after every wrap, clear and set. Priority mistakes (load versus increment, clear versus wrap, global reset) show up in the read that directly follows the write.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    // per-slot and global control bits: bit 0 count enable, bit 1 interrupt enable
    typedef struct packed {
        logic ie;
        logic ce;
    } ctl_t;

    localparam int OFF_VER   = 'h000;
    localparam int OFF_GCTL  = 'h008;
    localparam int OFF_GRST  = 'h00C;
    localparam int OFF_OVST  = 'h030;
    localparam int OFF_OVCLR = 'h034;
    localparam int OFF_OVSET = 'h03C;
    localparam int OFF_CNT   = 'h040;
    localparam int OFF_CCTL  = 'h100;
    localparam int OFF_ESEL  = 'h140;

    // slots below this index have hard-wired sources
    localparam int FIXED_SLOTS = 2;

endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int CTR_W = 28
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [CTR_W-1:0] ld_val_i,
    input  logic             inc_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CTR_W-1:0] TOP = '1;

    logic [CTR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (ld_i) begin
            cnt_d = ld_val_i;
        end else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == TOP);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evmon_evsel.sv
module evmon_evsel #(
    parameter int SEL_W = 8,
    localparam int NUM_EVT = 1 << SEL_W
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    assign hit_o = evt_i[sel_i];
endmodule

// File: rtl/evmon_rdmux.sv
module evmon_rdmux import evmon_pkg::*; #(
    parameter int          NUM_CTR = 8,
    parameter int          CTR_W   = 28,
    parameter int          SEL_W   = 8,
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] VERSION = 32'h0001_0002
) (
    input  logic [ADDR_W-1:0]                addr_i,
    input  ctl_t                             gctl_i,
    input  ctl_t [NUM_CTR-1:0]               cctl_i,
    input  logic [NUM_CTR-1:0][SEL_W-1:0]    esel_i,
    input  logic [NUM_CTR-1:0]               ovf_i,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]    cnt_i,
    output logic [31:0]                      rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFF_VER))  rdata_o = VERSION;
        if (addr_i == ADDR_W'(OFF_GCTL)) rdata_o = 32'(gctl_i);
        if (addr_i == ADDR_W'(OFF_OVST)) rdata_o = 32'(ovf_i);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr_i == ADDR_W'(OFF_CNT + 4 * i))  rdata_o = 32'(cnt_i[i]);
            if (addr_i == ADDR_W'(OFF_CCTL + 4 * i)) rdata_o = 32'(cctl_i[i]);
            if (i >= FIXED_SLOTS && addr_i == ADDR_W'(OFF_ESEL + 4 * i))
                rdata_o = 32'(esel_i[i]);
        end
    end
endmodule

// File: rtl/evmon_bank.sv
module evmon_bank import evmon_pkg::*; #(
    parameter int          NUM_CTR = 8,
    parameter int          CTR_W   = 28,
    parameter int          SEL_W   = 8,
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] VERSION = 32'h0001_0002
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    input  logic [(1<<SEL_W)-1:0]   evt_i,
    input  logic                    stall_i,
    output logic                    irq_o
);
    localparam int NUM_EVT = 1 << SEL_W;

    typedef struct packed {
        ctl_t                          gctl;
        ctl_t [NUM_CTR-1:0]            cctl;
        logic [NUM_CTR-1:0][SEL_W-1:0] esel;
        logic [NUM_CTR-1:0]            ovf;
    } state_t;

    state_t st_d, st_q;

    logic wr_gctl, wr_grst, wr_clr, wr_set;
    logic [NUM_CTR-1:0]            wr_cnt, wr_cctl, wr_esel;
    logic [NUM_CTR-1:0]            src, inc, wrap, ie_vec;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;

    assign wr_gctl = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_GCTL));
    assign wr_grst = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_GRST));
    assign wr_clr  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_OVCLR));
    assign wr_set  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_OVSET));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        assign wr_cnt[g]  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CNT + 4 * g));
        assign wr_cctl[g] = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CCTL + 4 * g));
        assign ie_vec[g]  = st_q.cctl[g].ie;

        if (g == 0) begin : g_cyc
            assign src[g]     = 1'b1;
            assign wr_esel[g] = 1'b0;
        end else if (g == 1) begin : g_waste
            assign src[g]     = stall_i;
            assign wr_esel[g] = 1'b0;
        end else begin : g_evt
            assign wr_esel[g] = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_ESEL + 4 * g));
            evmon_evsel #(.SEL_W(SEL_W)) u_sel (
                .evt_i (evt_i),
                .sel_i (st_q.esel[g]),
                .hit_o (src[g])
            );
        end

        assign inc[g] = st_q.gctl.ce && st_q.cctl[g].ce && src[g];

        evmon_counter #(.CTR_W(CTR_W)) u_ctr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clr_i    (wr_grst),
            .ld_i     (wr_cnt[g]),
            .ld_val_i (bus_wdata_i[CTR_W-1:0]),
            .inc_i    (inc[g]),
            .cnt_o    (cnt_all[g]),
            .wrap_o   (wrap[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_gctl) st_d.gctl = ctl_t'(bus_wdata_i[1:0]);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (wr_cctl[i]) st_d.cctl[i] = ctl_t'(bus_wdata_i[1:0]);
            if (wr_esel[i]) st_d.esel[i] = bus_wdata_i[SEL_W-1:0];
        end
        if (wr_grst) begin
            st_d.ovf = '0;
        end else begin
            st_d.ovf = (st_q.ovf & ~(wr_clr ? bus_wdata_i[NUM_CTR-1:0] : '0))
                     | (wr_set ? bus_wdata_i[NUM_CTR-1:0] : '0)
                     | wrap;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.gctl.ie && |(st_q.ovf & ie_vec);

    evmon_rdmux #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W),
        .VERSION (VERSION)
    ) u_rd (
        .addr_i  (bus_addr_i),
        .gctl_i  (st_q.gctl),
        .cctl_i  (st_q.cctl),
        .esel_i  (st_q.esel),
        .ovf_i   (st_q.ovf),
        .cnt_i   (cnt_all),
        .rdata_o (bus_rdata_o)
    );
endmodule

// File: rtl/evmon_bank_chk.sv
module evmon_bank_chk import evmon_pkg::*; #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 28,
    parameter int ADDR_W  = 12
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          wr_i,
    input logic [ADDR_W-1:0]             addr_i,
    input logic [31:0]                   wdata_i,
    input logic                          irq_i,
    input ctl_t                          gctl_i,
    input logic [NUM_CTR-1:0]            ovf_i,
    input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_i,
    input logic [NUM_CTR-1:0]            inc_i
);
    localparam logic [CTR_W-1:0] TOP = '1;

    logic grst_w;
    assign grst_w = wr_i && (addr_i == ADDR_W'(OFF_GRST));

    // R9: interrupt needs global interrupt enable and some status bit
    p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (gctl_i.ie && (|ovf_i)));

    // R3: with global count enable off and no write, counters hold
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gctl_i.ce && !wr_i) |=> $stable(cnt_i));

    // R10: global reset write zeroes counters and status
    p_grst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grst_w |=> (cnt_i == '0 && ovf_i == '0));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        // R5: wrap reaches zero and sets the status bit
        p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inc_i[g] && cnt_i[g] == TOP && !wr_i) |=> (ovf_i[g] && cnt_i[g] == '0));

        // R5, R7: status bit is sticky unless cleared or reset
        p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ovf_i[g] && !grst_w &&
             !(wr_i && addr_i == ADDR_W'(OFF_OVCLR) && wdata_i[g])) |=> ovf_i[g]);
    end
endmodule

bind evmon_bank evmon_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .irq_i   (irq_o),
    .gctl_i  (st_q.gctl),
    .ovf_i   (st_q.ovf),
    .cnt_i   (cnt_all),
    .inc_i   (inc)
);

// File: tb/evmon_bank_tb_top.sv
module evmon_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [255:0] evt = '0;
    logic        stall = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evmon_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
        .stall_i(stall), .irq_o(irq)
    );

    // behavioural reference state
    bit [31:0] m_cnt [8];
    bit [7:0]  m_ovf;
    bit [1:0]  m_g;
    bit [1:0]  m_cc [8];
    bit [7:0]  m_es [8];

    task automatic model_clear_all();
        for (int i = 0; i < 8; i++) begin
            m_cnt[i] = 0; m_cc[i] = 0; m_es[i] = 0;
        end
        m_ovf = 0; m_g = 0;
    endtask

    task automatic model_step();
        bit [7:0] wrapm = '0;
        if (wr && addr == 12'h00C) begin
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
            m_ovf = 0;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            bit s = (i == 0) ? 1'b1 : (i == 1) ? stall : evt[m_es[i]];
            if (wr && addr == 12'(64 + 4 * i)) m_cnt[i] = wdata & 32'h0FFF_FFFF;
            else if (m_g[0] && m_cc[i][0] && s) begin
                if (m_cnt[i] == 32'h0FFF_FFFF) begin m_cnt[i] = 0; wrapm[i] = 1'b1; end
                else m_cnt[i] = m_cnt[i] + 1;
            end
        end
        if (wr && addr == 12'h034) m_ovf = m_ovf & ~wdata[7:0];
        if (wr && addr == 12'h03C) m_ovf = m_ovf | wdata[7:0];
        m_ovf = m_ovf | wrapm;
        if (wr && addr == 12'h008) m_g = wdata[1:0];
        for (int i = 0; i < 8; i++) begin
            if (wr && addr == 12'(256 + 4 * i)) m_cc[i] = wdata[1:0];
            if (i >= 2 && wr && addr == 12'(320 + 4 * i)) m_es[i] = wdata[7:0];
        end
    endtask

    function automatic bit [31:0] model_rd(bit [11:0] a);
        bit [31:0] r = 0;
        if (a == 12'h000) r = 32'h0001_0002;
        if (a == 12'h008) r = {30'b0, m_g};
        if (a == 12'h030) r = {24'b0, m_ovf};
        for (int i = 0; i < 8; i++) begin
            if (a == 12'(64 + 4 * i))  r = m_cnt[i];
            if (a == 12'(256 + 4 * i)) r = {30'b0, m_cc[i]};
            if (i >= 2 && a == 12'(320 + 4 * i)) r = {24'b0, m_es[i]};
        end
        return r;
    endfunction

    function automatic bit model_irq();
        bit any = 0;
        for (int i = 0; i < 8; i++) if (m_ovf[i] && m_cc[i][1]) any = 1;
        return m_g[1] && any;
    endfunction

    initial model_clear_all();

    always @(posedge clk) begin
        if (!rst_n) model_clear_all();
        else        model_step();
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock interrupt comparison (R9)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R9 irq", {31'b0, irq}, {31'b0, model_irq()});
    end

    task automatic wr_reg(bit [11:0] a, bit [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_now(bit [11:0] a, string tag);
        addr = a; #1;
        chk(tag, rdata, model_rd(a));
    endtask

    task automatic rd_lit(bit [11:0] a, bit [31:0] exp, string tag);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_now(12'(64 + 4 * (k % 8)), "R3 counter sweep");
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_lit(12'h008, 0, "R1 gctl");
        rd_lit(12'h030, 0, "R1 status");
        for (int i = 0; i < 8; i++) rd_lit(12'(64 + 4 * i), 0, "R1 counter");
        chk("R1 irq", {31'b0, irq}, 0);
        // R2 version, write ignored
        rd_lit(12'h000, 32'h0001_0002, "R2 version");
        wr_reg(12'h000, 32'hDEAD_BEEF);
        rd_lit(12'h000, 32'h0001_0002, "R2 version after write");

        // R3 slot 0 and slot 1
        wr_reg(12'h100, 1);
        wr_reg(12'h104, 1);
        idle(4);
        rd_lit(12'h040, 0, "R3 no global enable");
        wr_reg(12'h008, 1);
        stall = 1'b1; idle(3);
        stall = 1'b0; idle(2);
        stall = 1'b1; idle(1);
        stall = 1'b0;

        // R4 selectors
        wr_reg(12'h144, 32'hFF);
        rd_lit(12'h144, 0, "R4 slot1 selector fixed");
        wr_reg(12'h140, 32'h7);
        rd_lit(12'h140, 0, "R4 slot0 selector fixed");
        wr_reg(12'h148, 5);
        wr_reg(12'h14C, 200);
        rd_lit(12'h14C, 200, "R4 selector readback");
        wr_reg(12'h108, 3);
        wr_reg(12'h10C, 1);
        evt[200] = 1'b1; idle(3);
        evt[200] = 1'b0; evt[201] = 1'b1; idle(2);
        evt[201] = 1'b0;
        rd_lit(12'h04C, 3, "R4 slot3 counted strobe 200 only");

        // R6 preload, R5 wrap
        wr_reg(12'h048, 32'hFFFF_FFFD);
        rd_lit(12'h048, 32'h0FFF_FFFD, "R6 preload low bits");
        evt[5] = 1'b1;
        repeat (3) @(negedge clk);
        evt[5] = 1'b0;
        rd_lit(12'h048, 0, "R5 wrapped to zero");
        rd_lit(12'h030, 32'h4, "R5 status bit 2");
        chk("R9 no global ie", {31'b0, irq}, 0);
        idle(3);
        rd_lit(12'h030, 32'h4, "R5 status sticky");
        wr_reg(12'h008, 3);
        chk("R9 irq raised", {31'b0, irq}, 1);

        // R7 clear
        wr_reg(12'h034, 0);
        rd_lit(12'h030, 32'h4, "R7 zero clear no effect");
        wr_reg(12'h034, 32'h4);
        rd_lit(12'h030, 0, "R7 cleared");
        chk("R9 irq dropped", {31'b0, irq}, 0);

        // R8 set, R9 per-slot ie
        wr_reg(12'h03C, 32'h20);
        rd_lit(12'h030, 32'h20, "R8 forced bit 5");
        chk("R9 slot ie off", {31'b0, irq}, 0);
        wr_reg(12'h114, 2);
        chk("R9 slot ie on", {31'b0, irq}, 1);
        wr_reg(12'h034, 32'h20);

        // R9 slot 0 with ie off sets status without irq
        wr_reg(12'h040, 32'h0FFF_FFFE);
        repeat (2) @(negedge clk);
        rd_lit(12'h030, 32'h1, "R9 slot0 status set");
        chk("R9 slot0 no irq", {31'b0, irq}, 0);

        // R6 write wins over increment
        wr_reg(12'h040, 32'h123);
        rd_lit(12'h040, 32'h123, "R6 load beats increment");
        idle(2);

        // R11 control width, status write ignored, unmapped
        wr_reg(12'h110, 32'hFFFF_FFFF);
        rd_lit(12'h110, 3, "R11 control bits");
        wr_reg(12'h030, 32'hFF);
        rd_lit(12'h030, 32'h1, "R11 status write ignored");
        rd_lit(12'h200, 0, "R11 unmapped");
        rd_lit(12'h034, 0, "R11 clear reads zero");

        // R10 global reset
        wr_reg(12'h00C, 1);
        rd_lit(12'h040, 0, "R10 counter zeroed");
        rd_lit(12'h030, 0, "R10 status zeroed");
        rd_lit(12'h008, 3, "R10 control kept");
        rd_lit(12'h148, 5, "R10 selector kept");

        // R3 global count disable holds
        wr_reg(12'h008, 2);
        idle(10);
        wr_reg(12'h008, 3);
        stall = 1'b1; evt[5] = 1'b1;
        idle(16);
        stall = 1'b0; evt[5] = 1'b0;
        idle(4);
        finish_run();
    end
endmodule